// File: doc/BRIEF.md
# External Bus Strobe Generator

This block produces the two timing strobes of a multiplexed external memory bus: an active-high address latch enable (ALE) and an active-low program store enable (PSEN). Both are placed inside a machine cycle of twelve oscillator periods. A free-running phase counter marks the position within that cycle and is also brought out, so that neighbouring logic can line up its own address and data timing.

Four control inputs shape the strobe pattern. The first marks a cycle that touches external data memory. The second marks a code-table read. The third says the core is fetching from external program memory. The fourth is a control bit held in a special function register that turns off free-running ALE. All four are captured once per machine cycle, at the edge that ends phase 11, and they steer the whole next cycle. A change at any other edge therefore cannot cut a strobe short or add one.

By default ALE gives two pulses per machine cycle, which is one sixth of the oscillator rate. A data-memory cycle drops the second of these. During external execution PSEN goes low twice per cycle, and a data-memory cycle removes both of those activations. When the disable bit is set, ALE stays at its idle high level. The exceptions are data-memory and code-table cycles, and the bit has no effect at all during external execution.

Top module: `ext_strobe_gen`

## Requirements
- R1: While `rst_n` is low, `phase` is 0, `ale` is 1 and `psen_n` is 1 after each clock edge, and the captured cycle flags are all cleared (the cycle after reset acts as if every control input were 0).
- R2: `phase` counts 0,1,...,11 with one step per clock and returns to 0 after 11.
- R3: In a cycle with the data, table and disable flags all clear, `ale` is 1 exactly at phases 0, 1, 6 and 7.
- R4: In a cycle flagged as an external data access, `ale` is 1 at phases 0 and 1 only; the pulse at phases 6 and 7 is dropped.
- R5: In a cycle captured with external execution set and the data flag clear, `psen_n` is 0 exactly at phases 3, 4, 5, 9, 10 and 11.
- R6: In a cycle flagged as an external data access, `psen_n` stays 1 for all twelve phases, even with external execution set.
- R7: In a cycle captured with external execution clear, `psen_n` stays 1 for all twelve phases.
- R8: In a cycle captured with the disable bit set and the external execution, data and table flags all clear, `ale` stays 1 for all twelve phases.
- R9: With the disable bit set, a data cycle or a table-read cycle produces the ALE pattern of R4 or R3 respectively.
- R10: With external execution set, the disable bit has no effect: `ale` follows R3 or R4.
- R11: The control inputs are sampled only at the clock edge where `phase` is 11. A change at any other edge leaves `ale` and `psen_n` unchanged for the rest of the current cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock, one period per phase |
| rst_n | input | 1 | Synchronous active-low reset |
| xdata_cyc | input | 1 | Coming cycle accesses external data memory |
| ctab_rd | input | 1 | Coming cycle is a code-table read |
| ext_exec | input | 1 | Core fetches from external program memory |
| ale_off | input | 1 | Register bit that suppresses free-running ALE |
| ale | output | 1 | Address latch enable, active high |
| psen_n | output | 1 | Program store enable, active low |
| phase | output | 4 | Position within the 12-period machine cycle |

## Verification
A phase counter that skips or repeats a count moves every later strobe. It shows up at the `phase` port on the very next edge, and in the strobe positions within the same cycle. A cycle flag that is captured at the wrong edge, or held wrongly, changes the strobe pattern of the next cycle, so a fault is visible within at most twelve clocks. The stimulus changes the inputs in the middle of cycles, which means flags that are sampled too early or too late give the wrong pattern instead of going unseen.

// File: rtl/strobe_pkg.sv
// Shared types and timing constants for the external bus strobe generator.
package strobe_pkg;

    // Control flags captured once per machine cycle.
    typedef struct packed {
        logic ext_exec;  // fetching from external program memory
        logic ale_off;   // free-running ALE suppressed
        logic xdata;     // cycle accesses external data memory
        logic ctab;      // cycle is a code-table read
    } cyc_attr_t;

    localparam cyc_attr_t ATTR_CLEAR = '{ext_exec: 1'b0, ale_off: 1'b0, xdata: 1'b0, ctab: 1'b0};

endpackage

// File: rtl/mc_phase_counter.sv
// Machine-cycle phase counter.
// Counts 0 .. PHASES-1 with one step per clock and wraps. It flags the last
// phase so that other logic can sample at the cycle boundary.
// Assumes a synchronous active-low reset that forces phase 0.
module mc_phase_counter #(
    parameter int PHASES = 12,
    parameter int PH_W   = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] phase,
    output logic            last
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);

    // Advance the phase and wrap after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= '0;
        else if (phase == LAST_PH)
            phase <= '0;
        else
            phase <= phase + 1'b1;
    end

    // Mark the final phase of the machine cycle.
    always_comb last = (phase == LAST_PH);
endmodule

// File: rtl/cycle_attr_reg.sv
// Cycle attribute register.
// Captures the control flags at the edge that closes a machine cycle and holds
// them unchanged for the whole next cycle.
// Assumes `capture` is high for exactly one clock per machine cycle.
module cycle_attr_reg
    import strobe_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      capture,
    input  cyc_attr_t attr_in,
    output cyc_attr_t attr_q
);
    // Load new flags at the cycle boundary and keep them otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            attr_q <= ATTR_CLEAR;
        else if (capture)
            attr_q <= attr_in;
    end
endmodule

// File: rtl/strobe_decode.sv
// Strobe decoder.
// Turns the phase and the held cycle flags into the ALE and PSEN levels. Each
// strobe has two slots per cycle, set by start phase and width.
// Assumes the flags stay constant across the cycle. The output depends only on
// registered state, so it is free of input-induced glitches.
module strobe_decode
    import strobe_pkg::*;
#(
    parameter int PH_W      = 4,
    parameter int ALE_A     = 0,
    parameter int ALE_B     = 6,
    parameter int ALE_WID   = 2,
    parameter int PSEN_A    = 3,
    parameter int PSEN_B    = 9,
    parameter int PSEN_WID  = 3
) (
    input  logic [PH_W-1:0] phase,
    input  cyc_attr_t       attr,
    output logic            ale,
    output logic            psen_n
);
    logic [1:0] ale_slot;
    logic [1:0] psen_slot;
    logic       ale_pulse;
    logic       ale_gate;

    // Return whether the phase lies in a window given by start and width.
    function automatic logic in_win(input logic [PH_W-1:0] ph, input int start, input int wid);
        int p;
        p = int'(ph);
        return (p >= start) && (p < start + wid);
    endfunction

    localparam int ALE_START [2]  = '{ALE_A, ALE_B};
    localparam int PSEN_START [2] = '{PSEN_A, PSEN_B};

    // One window decoder per slot for each strobe.
    for (genvar s = 0; s < 2; s++) begin : g_slot
        always_comb ale_slot[s]  = in_win(phase, ALE_START[s], ALE_WID);
        always_comb psen_slot[s] = in_win(phase, PSEN_START[s], PSEN_WID);
    end

    // ALE pulse pattern: the second slot is dropped in a data-memory cycle.
    always_comb ale_pulse = ale_slot[0] | (ale_slot[1] & ~attr.xdata);

    // ALE runs freely unless disabled; the disable is overridden by external
    // execution, data-memory cycles and table reads.
    always_comb ale_gate = ~attr.ale_off | attr.ext_exec | attr.xdata | attr.ctab;

    // Suppressed ALE rests at the idle high level of the weak pull-up.
    always_comb ale = ale_gate ? ale_pulse : 1'b1;

    // PSEN fires twice per cycle in external execution, never in data cycles.
    always_comb psen_n = ~(attr.ext_exec & ~attr.xdata & (|psen_slot));
endmodule

// File: rtl/ext_strobe_gen.sv
// External bus strobe generator, top level.
// Ties the phase counter, the cycle attribute register and the strobe
// decoder together. Control inputs are sampled at the end of phase PHASES-1.
// Assumes clk is the oscillator clock and rst_n is synchronous.
module ext_strobe_gen
    import strobe_pkg::*;
#(
    parameter int PHASES    = 12,
    parameter int ALE_A     = 0,
    parameter int ALE_B     = 6,
    parameter int ALE_WID   = 2,
    parameter int PSEN_A    = 3,
    parameter int PSEN_B    = 9,
    parameter int PSEN_WID  = 3,
    localparam int PH_W     = $clog2(PHASES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            xdata_cyc,
    input  logic            ctab_rd,
    input  logic            ext_exec,
    input  logic            ale_off,
    output logic            ale,
    output logic            psen_n,
    output logic [PH_W-1:0] phase
);
    logic      cyc_last;
    cyc_attr_t attr_next;
    cyc_attr_t attr_cur;

    // Gather the raw control inputs into one attribute word.
    always_comb attr_next = '{ext_exec: ext_exec, ale_off: ale_off,
                              xdata: xdata_cyc, ctab: ctab_rd};

    mc_phase_counter #(.PHASES(PHASES), .PH_W(PH_W)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .phase (phase),
        .last  (cyc_last)
    );

    cycle_attr_reg u_attr (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cyc_last),
        .attr_in (attr_next),
        .attr_q  (attr_cur)
    );

    strobe_decode #(
        .PH_W(PH_W), .ALE_A(ALE_A), .ALE_B(ALE_B), .ALE_WID(ALE_WID),
        .PSEN_A(PSEN_A), .PSEN_B(PSEN_B), .PSEN_WID(PSEN_WID)
    ) u_dec (
        .phase  (phase),
        .attr   (attr_cur),
        .ale    (ale),
        .psen_n (psen_n)
    );
endmodule

// File: rtl/ext_strobe_gen_chk.sv
// Checker for the external bus strobe generator, bound to the top level.
// Relates the counter, the held flags and the strobe outputs over time.
module ext_strobe_gen_chk #(
    parameter int PHASES  = 12,
    parameter int ALE_B   = 6,
    parameter int PSEN_A  = 3,
    parameter int PH_W    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PH_W-1:0] phase,
    input logic            ale,
    input logic            psen_n,
    input logic [3:0]      attr_bits
);
    localparam logic [PH_W-1:0] LAST_PH = PH_W'(PHASES - 1);
    logic f_ext, f_off, f_xd, f_ct;
    always_comb {f_ext, f_off, f_xd, f_ct} = attr_bits;

    a_r2_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        phase == LAST_PH |=> phase == '0);
    a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
        phase != LAST_PH |=> phase == $past(phase) + 1'b1);
    a_r11_flags_held: assert property (@(posedge clk) disable iff (!rst_n)
        phase != LAST_PH |=> $stable(attr_bits));
    a_r7_psen_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !f_ext |-> psen_n);
    a_r6_psen_xdata: assert property (@(posedge clk) disable iff (!rst_n)
        f_xd |-> psen_n);
    a_r5_psen_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (f_ext && !f_xd && phase == PH_W'(PSEN_A)) |-> !psen_n);
    a_r4_ale_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (f_xd && phase == PH_W'(ALE_B)) |-> !ale);
    a_r8_ale_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (f_off && !f_ext && !f_xd && !f_ct) |-> ale);
endmodule

bind ext_strobe_gen ext_strobe_gen_chk #(
    .PHASES(PHASES), .ALE_B(ALE_B), .PSEN_A(PSEN_A), .PH_W(PH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .ale       (ale),
    .psen_n    (psen_n),
    .attr_bits (attr_cur)
);

// File: tb/tb_ext_strobe_gen.sv
// Self-checking bench: a reference model of the phase and flags, directed
// flag combinations, then seeded random mid-cycle flag changes.
module tb_ext_strobe_gen;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic xdata_cyc = 1'b0, ctab_rd = 1'b0, ext_exec = 1'b0, ale_off = 1'b0;
    logic ale, psen_n;
    logic [3:0] phase;

    int checks = 0;
    int fails  = 0;

    // Reference state: phase and flags held for the current cycle.
    int   m_ph = 0;
    logic m_ext = 0, m_off = 0, m_xd = 0, m_ct = 0;

    ext_strobe_gen dut (
        .clk(clk), .rst_n(rst_n), .xdata_cyc(xdata_cyc), .ctab_rd(ctab_rd),
        .ext_exec(ext_exec), .ale_off(ale_off),
        .ale(ale), .psen_n(psen_n), .phase(phase)
    );

    always #5 clk = ~clk;

    // Reference model update at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 0; m_ext <= 0; m_off <= 0; m_xd <= 0; m_ct <= 0;
        end else begin
            m_ph <= (m_ph == 11) ? 0 : m_ph + 1;
            if (m_ph == 11) begin
                m_ext <= ext_exec; m_off <= ale_off; m_xd <= xdata_cyc; m_ct <= ctab_rd;
            end
        end
    end

    function automatic logic exp_ale(int ph, logic e, logic o, logic x, logic c);
        logic pulse;
        pulse = (ph == 0 || ph == 1) || (!x && (ph == 6 || ph == 7));
        if (o && !e && !x && !c) return 1'b1;
        return pulse;
    endfunction

    function automatic logic exp_psen(int ph, logic e, logic x);
        logic slot;
        slot = (ph >= 3 && ph <= 5) || (ph >= 9 && ph <= 11);
        return !(e && !x && slot);
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare outputs with the model; name the requirement that applies.
    task automatic check_cycle();
        string ra, rp;
        logic  moved;
        moved = (ext_exec != m_ext) || (ale_off != m_off) ||
                (xdata_cyc != m_xd) || (ctab_rd != m_ct);
        if (moved)                          ra = "R11";
        else if (m_off && m_ext)            ra = "R10";
        else if (m_off && !m_xd && !m_ct)   ra = "R8";
        else if (m_off)                     ra = "R9";
        else if (m_xd)                      ra = "R4";
        else                                ra = "R3";
        if (moved)       rp = "R11";
        else if (!m_ext) rp = "R7";
        else if (m_xd)   rp = "R6";
        else             rp = "R5";
        check("R2", "phase", int'(phase), m_ph);
        check(ra, "ale", int'(ale), int'(exp_ale(m_ph, m_ext, m_off, m_xd, m_ct)));
        check(rp, "psen_n", int'(psen_n), int'(exp_psen(m_ph, m_ext, m_xd)));
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #1ms;
        checks++; fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'h0005_1EED));
        // R1: reset state after edges with reset held low.
        repeat (3) @(negedge clk);
        check("R1", "phase in reset", int'(phase), 0);
        check("R1", "ale in reset", int'(ale), 1);
        check("R1", "psen_n in reset", int'(psen_n), 1);
        // Drive flags during reset; R1 says they must not be captured.
        ext_exec = 1'b1; xdata_cyc = 1'b1;
        @(negedge clk);
        ext_exec = 1'b0; xdata_cyc = 1'b0;
        rst_n = 1'b1;
        // First cycle after reset behaves as all flags clear (R1, R3).
        for (int i = 0; i < 12; i++) begin
            check_cycle();
            @(negedge clk);
        end
        // Directed: every flag combination held for over two cycles.
        for (int c = 0; c < 16; c++) begin
            {ext_exec, ale_off, xdata_cyc, ctab_rd} = 4'(c);
            for (int i = 0; i < 30; i++) begin
                @(negedge clk);
                check_cycle();
            end
        end
        // Random: flags change at random edges, mostly mid-cycle (R11).
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            check_cycle();
            if ($urandom_range(3) == 0)
                {ext_exec, ale_off, xdata_cyc, ctab_rd} = 4'($urandom_range(15));
        end
        finish_run();
    end
endmodule